// File: doc/BRIEF.md
# I2C Bus Condition Monitor

This block watches the clock and data wires of an open-drain two-wire bus and reports what kind of activity is on them. It never drives either wire. Both wires are sampled on the system clock through two-flop synchronizers. A register keeps the previously synchronized pair. Each change between the two samples is classified by a five-state machine as one of: start, stop, clock fall, other single-line change, or a change of both lines at once.

The monitor reports start and stop conditions as one-cycle pulses. It reports three levels: the bus is free, the bus has been taken by an I2C transfer, or the bus carries activity that never began with a valid start. A separate sticky error flag says that both lines moved between two samples, so the order of the two edges is lost. A host can use these outputs to tell when the wires can be reused for other serial traffic, or to spot a broken transaction. Decoding addresses, data, acknowledge bits and direction is left to other logic.

Every event reaches the outputs on the third rising clock edge after the line change is set up. Two edges are spent in the synchronizer and one in the state register.

Top module: `i2c_cond_monitor`

## Requirements
- R1: After reset, `bus_idle` is 1 and `start_pulse`, `stop_pulse`, `bus_seized`, `foreign_act` and `overrun` are all 0.
- R2: When data falls while clock stays high, outside the error state, `start_pulse` is 1 for exactly one cycle. It appears on the third rising edge after the change. A start is never reported together with a stop.
- R3: When clock falls after a start, `bus_seized` goes to 1. It stays at 1 while data changes only with clock low. The bus can become seized only from the armed state that follows a start.
- R4: When data rises while clock stays high, in any state, `stop_pulse` is 1 for one cycle. At the same time `bus_idle` is 1 and `bus_seized` and `foreign_act` are 0.
- R5: A start seen while the bus is seized is a repeated start. It pulses `start_pulse` again, and `bus_seized` stays at 1.
- R6: From the free state, a single-line change that is not a start sets `foreign_act`. This includes a clock fall, or data toggling while clock is low. `foreign_act` stays at 1 with no start or stop pulses until a start or a stop arrives. The monitor never goes straight from seized to foreign.
- R7: A start seen while `foreign_act` is 1 pulses `start_pulse` and clears `foreign_act`. The next clock fall then seizes the bus.
- R8: When both lines differ from the previous sample, `overrun` is set and the machine enters the error state. In that state `bus_idle`, `bus_seized` and `foreign_act` are all 0, and neither pulse is produced.
- R9: `overrun` stays at 1 until `ovr_clr`. The machine stays in the error state through single-line changes, including data falling with clock high. It leaves only at a stop, which gives `stop_pulse` and `bus_idle` while `overrun` is still 1.
- R10: A one-cycle `ovr_clr` clears `overrun` on the next rising edge. A new double change in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock wire as seen at the pin |
| sda_in | input | 1 | Bus data wire as seen at the pin |
| ovr_clr | input | 1 | Strobe that clears the sticky overrun flag |
| start_pulse | output | 1 | One-cycle pulse on a start or repeated start |
| stop_pulse | output | 1 | One-cycle pulse on a stop |
| bus_idle | output | 1 | Level: bus free after reset or a stop |
| bus_seized | output | 1 | Level: an I2C transfer owns the bus |
| foreign_act | output | 1 | Level: activity that did not begin with a start |
| overrun | output | 1 | Sticky flag: both lines changed between two samples |

## Verification
The checker tests several rules on every cycle:
- the start and stop pulses never coincide and never last two cycles;
- a stop always shows up with the idle level;
- the three levels are mutually exclusive;
- seizure never follows the free or foreign state directly;
- the overrun flag holds until it is cleared.

Other behaviour can only be shown by the bench's scenarios, because it depends on line sequences. These cover:
- the order of start, stop and repeated-start pulses in a real transfer;
- data toggling with clock low, which must stay silent;
- a start that rescues foreign activity;
- an ambiguous double change in the free state and during a transfer;
- a start inside the error state, which must be ignored.

// File: rtl/icm_pkg.sv
// Shared types for the bus condition monitor.
package icm_pkg;

    // One sample of the two bus wires.
    typedef struct packed {
        logic scl;
        logic sda;
    } line_pair_t;

    // Classification of the change between two consecutive samples.
    typedef struct packed {
        logic start;     // data fell, clock high and steady
        logic stop;      // data rose, clock high and steady
        logic scl_fall;  // clock fell, data steady
        logic other;     // any other single-line change
        logic both;      // both lines changed: order unknown
    } line_evt_t;

    // Monitor states.
    typedef enum logic [2:0] {
        ST_FREE    = 3'd0,
        ST_ARMED   = 3'd1,
        ST_OWNED   = 3'd2,
        ST_FOREIGN = 3'd3,
        ST_FAULT   = 3'd4
    } mon_state_t;

endpackage

// File: rtl/icm_sync.sv
// Multi-stage synchronizer for asynchronous bus wires.
// Assumes: the wires are slow compared with clk; the reset value is the
// bus idle level, so reset itself raises no event.
module icm_sync #(
    parameter int              WIDTH   = 2,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First flop: capture the raw pins.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[s] <= RST_VAL;
                else        stage[s] <= d;
            end
        end else begin : g_next
            // Later flops: settle the previous stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[s] <= RST_VAL;
                else        stage[s] <= stage[s-1];
            end
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/icm_edge.sv
// Keeps the previous synchronized sample and classifies the change
// between it and the current one.
// Assumes: cur is already synchronous to clk; reset value is idle (11).
module icm_edge
    import icm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  line_pair_t cur,
    output line_evt_t  evt
);
    line_pair_t prev;
    logic       scl_d;
    logic       sda_d;

    // Remember the last sample for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '{scl: 1'b1, sda: 1'b1};
        else        prev <= cur;
    end

    // Decode the change into one event class.
    always_comb begin
        scl_d        = cur.scl ^ prev.scl;
        sda_d        = cur.sda ^ prev.sda;
        evt.both     = scl_d & sda_d;
        evt.start    = !scl_d & sda_d & cur.scl & !cur.sda;
        evt.stop     = !scl_d & sda_d & cur.scl & cur.sda;
        evt.scl_fall = scl_d & !sda_d & !cur.scl;
        evt.other    = (scl_d ^ sda_d) & !evt.start & !evt.stop & !evt.scl_fall;
    end
endmodule

// File: rtl/icm_fsm.sv
// Bus condition state machine and registered event pulses.
// Assumes: at most one event class in evt is set per cycle, except that
// 'both' overrides the rest.
module icm_fsm
    import icm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  line_evt_t  evt,
    output mon_state_t state,
    output logic       start_q,
    output logic       stop_q
);
    mon_state_t state_nx;

    // Next-state decision from the current state and the line event.
    always_comb begin
        state_nx = state;
        if (evt.both) begin
            state_nx = ST_FAULT;
        end else if (evt.stop) begin
            state_nx = ST_FREE;
        end else begin
            unique case (state)
                ST_FREE: begin
                    if (evt.start)                      state_nx = ST_ARMED;
                    else if (evt.scl_fall || evt.other) state_nx = ST_FOREIGN;
                end
                ST_ARMED:   if (evt.scl_fall) state_nx = ST_OWNED;
                ST_OWNED:   state_nx = ST_OWNED;
                ST_FOREIGN: if (evt.start)    state_nx = ST_ARMED;
                ST_FAULT:   state_nx = ST_FAULT;
                default:    state_nx = ST_FREE;
            endcase
        end
    end

    // State register and one-cycle event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_FREE;
            start_q <= 1'b0;
            stop_q  <= 1'b0;
        end else begin
            state   <= state_nx;
            start_q <= !evt.both && evt.start && (state != ST_FAULT);
            stop_q  <= !evt.both && evt.stop;
        end
    end
endmodule

// File: rtl/icm_ovr_flag.sv
// Sticky overrun flag: set by an ambiguous double change, cleared by
// a strobe. Assumes set takes priority when both arrive together.
module icm_ovr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag
);
    // Hold the flag until an explicit clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag <= 1'b0;
        else if (set_i) flag <= 1'b1;
        else if (clr_i) flag <= 1'b0;
    end
endmodule

// File: rtl/i2c_cond_monitor.sv
// Top of the passive two-wire bus condition monitor.
// Assumes: scl_in/sda_in are asynchronous; it only observes, never drives.
// Latency: a line change shows on the outputs on the third rising edge.
module i2c_cond_monitor
    import icm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    input  logic ovr_clr,
    output logic start_pulse,
    output logic stop_pulse,
    output logic bus_idle,
    output logic bus_seized,
    output logic foreign_act,
    output logic overrun
);
    localparam int LINES = $bits(line_pair_t);

    logic [LINES-1:0] sync_q;
    line_pair_t       cur;
    line_evt_t        evt;
    mon_state_t       state;

    icm_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_in, sda_in}),
        .q     (sync_q)
    );

    assign cur = line_pair_t'(sync_q);

    icm_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .cur   (cur),
        .evt   (evt)
    );

    icm_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt),
        .state   (state),
        .start_q (start_pulse),
        .stop_q  (stop_pulse)
    );

    icm_ovr_flag u_ovr (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (evt.both),
        .clr_i (ovr_clr),
        .flag  (overrun)
    );

    // Status levels decoded from the state register.
    assign bus_idle    = (state == ST_FREE);
    assign bus_seized  = (state == ST_OWNED);
    assign foreign_act = (state == ST_FOREIGN);
endmodule

// File: rtl/icm_checker.sv
// Protocol checker for the bus condition monitor, bound to the top.
module icm_checker (
    input logic clk,
    input logic rst_n,
    input logic ovr_clr,
    input logic start_pulse,
    input logic stop_pulse,
    input logic bus_idle,
    input logic bus_seized,
    input logic foreign_act,
    input logic overrun
);
    AST_NO_START_STOP_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_pulse && stop_pulse)); // R2
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse); // R2
    AST_SEIZE_ONLY_FROM_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_idle || foreign_act) |=> !bus_seized); // R3
    AST_STOP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |=> !stop_pulse); // R4
    AST_STOP_GIVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |-> (bus_idle && !bus_seized && !foreign_act)); // R4
    AST_LEVELS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_idle, bus_seized, foreign_act})); // R4
    AST_SEIZED_NOT_FOREIGN: assert property (@(posedge clk) disable iff (!rst_n)
        bus_seized |=> !foreign_act); // R6
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovr_clr) |=> overrun); // R9
endmodule

bind i2c_cond_monitor icm_checker u_icm_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .ovr_clr     (ovr_clr),
    .start_pulse (start_pulse),
    .stop_pulse  (stop_pulse),
    .bus_idle    (bus_idle),
    .bus_seized  (bus_seized),
    .foreign_act (foreign_act),
    .overrun     (overrun)
);

// File: tb/tb_i2c_cond_monitor.sv
// Scoreboard bench: the driver queues expected pulses, a monitor pops them.
module tb_i2c_cond_monitor;
    localparam int EV_NONE  = 0;
    localparam int EV_START = 1;
    localparam int EV_STOP  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_in = 1'b1;
    logic sda_in = 1'b1;
    logic ovr_clr = 1'b0;
    logic start_pulse, stop_pulse, bus_idle, bus_seized, foreign_act, overrun;

    int checks = 0;
    int fails  = 0;
    int exp_q[$];
    bit done = 1'b0;

    always #10 clk = ~clk;

    i2c_cond_monitor dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_in      (scl_in),
        .sda_in      (sda_in),
        .ovr_clr     (ovr_clr),
        .start_pulse (start_pulse),
        .stop_pulse  (stop_pulse),
        .bus_idle    (bus_idle),
        .bus_seized  (bus_seized),
        .foreign_act (foreign_act),
        .overrun     (overrun)
    );

    // Monitor: every observed pulse must match the head of the queue (R2, R4).
    always @(negedge clk) begin : mon
        int got;
        int want;
        if (rst_n && !done && (start_pulse || stop_pulse)) begin
            got = start_pulse ? EV_START : EV_STOP;
            checks++;
            if (start_pulse && stop_pulse) begin
                fails++;
                $display("FAIL R2 start and stop together actual=both expected=one");
            end else if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R2/R4 unexpected pulse actual=%0d expected=%0d", got, EV_NONE);
            end else begin
                want = exp_q.pop_front();
                if (got != want) begin
                    fails++;
                    $display("FAIL R2/R4 pulse kind actual=%0d expected=%0d", got, want);
                end
            end
        end
    end

    // Driver: set both wires, queue the expected pulse, let it settle.
    task automatic step(input logic c, input logic d, input int ev);
        @(negedge clk);
        scl_in = c;
        sda_in = d;
        if (ev != EV_NONE) exp_q.push_back(ev);
        repeat (4) @(negedge clk);
    endtask

    // Compare the status levels against expectations.
    task automatic chk(input string req, input logic ei, input logic es,
                       input logic ef, input logic eo);
        checks++;
        if ({bus_idle, bus_seized, foreign_act, overrun} !== {ei, es, ef, eo}) begin
            fails++;
            $display("FAIL %s idle/seized/foreign/overrun actual=%b%b%b%b expected=%b%b%b%b",
                     req, bus_idle, bus_seized, foreign_act, overrun, ei, es, ef, eo);
        end
    endtask

    // Strobe the clear input for one cycle.
    task automatic clear_ovr();
        @(negedge clk);
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        @(negedge clk);
    endtask

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (start_pulse || stop_pulse) begin
            fails++;
            $display("FAIL R1 pulses after reset actual=%b%b expected=00", start_pulse, stop_pulse);
        end
        chk("R1", 1, 0, 0, 0);

        // Start, seize, data bits, repeated start, stop.
        step(1, 0, EV_START); chk("R2", 0, 0, 0, 0);
        step(0, 0, EV_NONE);  chk("R3", 0, 1, 0, 0);
        step(0, 1, EV_NONE); step(1, 1, EV_NONE); step(0, 1, EV_NONE);
        step(0, 0, EV_NONE); step(1, 0, EV_NONE); step(0, 0, EV_NONE);
        chk("R3", 0, 1, 0, 0);
        step(0, 1, EV_NONE); step(1, 1, EV_NONE);
        step(1, 0, EV_START); chk("R5", 0, 1, 0, 0);
        step(0, 0, EV_NONE); step(1, 0, EV_NONE);
        step(1, 1, EV_STOP);  chk("R4", 1, 0, 0, 0);

        // Foreign activity, then rescued by a start.
        step(0, 1, EV_NONE);  chk("R6", 0, 0, 1, 0);
        step(0, 0, EV_NONE); step(0, 1, EV_NONE); step(0, 0, EV_NONE); step(0, 1, EV_NONE);
        chk("R6", 0, 0, 1, 0);
        step(1, 1, EV_NONE);  chk("R6", 0, 0, 1, 0);
        step(1, 0, EV_START); chk("R7", 0, 0, 0, 0);
        step(0, 0, EV_NONE);  chk("R7", 0, 1, 0, 0);
        step(1, 0, EV_NONE);
        step(1, 1, EV_STOP);  chk("R4", 1, 0, 0, 0);

        // Foreign activity ended by a stop.
        step(0, 1, EV_NONE); step(0, 0, EV_NONE); step(1, 0, EV_NONE);
        chk("R6", 0, 0, 1, 0);
        step(1, 1, EV_STOP);  chk("R4", 1, 0, 0, 0);

        // Double change from the free state.
        step(0, 0, EV_NONE);  chk("R8", 0, 0, 0, 1);
        step(1, 0, EV_NONE);  chk("R9", 0, 0, 0, 1);
        step(1, 1, EV_STOP);  chk("R9", 1, 0, 0, 1);
        clear_ovr();          chk("R10", 1, 0, 0, 0);

        // Double change during a transfer; start inside fault is ignored.
        step(1, 0, EV_START); step(0, 0, EV_NONE); chk("R3", 0, 1, 0, 0);
        step(1, 1, EV_NONE);  chk("R8", 0, 0, 0, 1);
        step(1, 0, EV_NONE);  chk("R9", 0, 0, 0, 1);
        step(1, 1, EV_STOP);  chk("R9", 1, 0, 0, 1);
        clear_ovr();          chk("R10", 1, 0, 0, 0);

        repeat (5) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R2/R4 missing pulses actual=%0d expected=0", exp_q.size());
        end
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule